// File: doc/BRIEF.md
# Dual-Threshold Fault Qualifier

This block turns four asynchronous comparator flags into qualified fault requests for a power-stage supervisor. Each flag is first synchronized to the block clock. It then has to stay high without a break for a set number of timebase ticks before it counts as a fault. The ticks arrive as single-cycle enables on the `tick` input, derived elsewhere from a reference clock. Every hold length is a parameter given in ticks.

One sense pin is compared against two thresholds. The shallow threshold (temperature) qualifies slowly. The deep threshold (external shutdown) qualifies within a few ticks. The same pin therefore works both as a slow thermal sensor and as a fast shutdown input. A feedback-overload flag has the longest hold. The supply over-voltage flag needs no hold at all.

Each qualified fault produces a single-cycle request bit together with a mode tag. Tag 1 means the supervisor must latch off. Tag 0 means it may auto-restart. Channel order on the vectors is fixed: bit 0 is temperature, bit 1 is external shutdown, bit 2 is overload and bit 3 is over-voltage.

Top module: `fault_qualifier`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `fault_req` and `fault_latch` are all zero.
- R2: Each raw flag passes through a two-flop synchronizer. A raw flag that rises just after clock edge N can produce an immediate request no earlier than the output sampled after edge N+3.
- R3: Bit 0 (temperature) pulses on the clock edge that samples the TEMP_TICKS-th tick seen while the synchronized temperature flag has been continuously high.
- R4: Bit 1 (external shutdown) pulses the same way after EXT_TICKS ticks. It runs independently of bit 0 even though both come from the same pin.
- R5: Bit 2 (overload) pulses the same way after OVLD_TICKS ticks.
- R6: Bit 3 (over-voltage) pulses for one cycle on the edge after its synchronized flag rises. It does not wait for `tick`.
- R7: `fault_latch[i]` is 1 together with `fault_req[i]` on bits 0, 1 and 3, and equals OVLD_LATCH on bit 2. It is 0 whenever `fault_req[i]` is 0.
- R8: A request is a single-cycle pulse. It is not repeated while the flag stays high, and it can recur only after the flag has dropped and risen again.
- R9: A synchronized flag that drops before its hold expires clears its accumulated tick count to zero.
- R10: Cycles without `tick` do not advance any hold timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one cycle wide |
| temp_low_raw | input | 1 | Sense pin below the thermal threshold (asynchronous) |
| ext_low_raw | input | 1 | Sense pin below the shutdown threshold (asynchronous) |
| fb_high_raw | input | 1 | Feedback above the overload threshold (asynchronous) |
| vdd_high_raw | input | 1 | Supply above the over-voltage threshold (asynchronous) |
| fault_req | output | 4 | One-cycle fault requests, bit order temp/ext/overload/over-voltage |
| fault_latch | output | 4 | Mode tag for each request bit (1 = latch, 0 = auto-restart) |

## Verification
The assertions assume that `tick` is a clean single-cycle enable produced in the block's own clock domain. They assume that the raw flags may change at any cycle, but never more than once between two clock edges, so that each synchronized level is a plain delayed copy of its input. The bench drives every input one time unit after a rising edge and holds it through the next edge. It derives `tick` from its own cycle count, or forces it low for a whole phase, so that the tick stream always has the form the block expects.

// File: rtl/fq_pkg.sv
package fq_pkg;

  localparam int NCH      = 4;
  localparam int CH_TEMP  = 0;
  localparam int CH_EXT   = 1;
  localparam int CH_OVLD  = 2;
  localparam int CH_OVV   = 3;

  // Counter width that can hold the value lim (at least one bit).
  function automatic int cnt_w(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // Fire condition of a timed channel: this tick completes the hold.
  function automatic logic hold_done(input logic lvl, input logic tk,
                                     input int unsigned cnt,
                                     input int unsigned lim);
    return lvl && tk && (cnt + 1 == lim);
  endfunction

endpackage

// File: rtl/fq_sync.sv
module fq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/fq_hold_timer.sv
module fq_hold_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level,
  output logic fire,
  output logic idle
);

  generate
    if (LIMIT == 0) begin : g_edge
      // Immediate channel: qualify on the rising edge of the level.
      logic prev;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
      end
      assign fire = level && !prev;
      assign idle = !prev;
    end else begin : g_count
      localparam int W = fq_pkg::cnt_w(LIMIT);
      localparam logic [W-1:0] TOP = W'(LIMIT);
      logic [W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt <= '0;
        else if (!level)               cnt <= '0;
        else if (tick && cnt != TOP)   cnt <= cnt + 1'b1;
      end
      assign fire = fq_pkg::hold_done(level, tick, int'(cnt), LIMIT);
      assign idle = (cnt == '0);
    end
  endgenerate

endmodule

// File: rtl/fault_qualifier.sv
module fault_qualifier #(
  parameter int unsigned TEMP_TICKS  = 2900,
  parameter int unsigned EXT_TICKS   = 37,
  parameter int unsigned OVLD_TICKS  = 11500,
  parameter int unsigned OVV_TICKS   = 0,
  parameter bit          OVLD_LATCH  = 1'b0,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       temp_low_raw,
  input  logic       ext_low_raw,
  input  logic       fb_high_raw,
  input  logic       vdd_high_raw,
  output logic [3:0] fault_req,
  output logic [3:0] fault_latch
);
  import fq_pkg::*;

  localparam int unsigned LIMITS [NCH] = '{TEMP_TICKS, EXT_TICKS, OVLD_TICKS, OVV_TICKS};
  localparam logic [NCH-1:0] LATCH_MASK = {1'b1, OVLD_LATCH, 1'b1, 1'b1};

  logic [NCH-1:0] raw_flags;
  logic [NCH-1:0] sync_lvl;
  logic [NCH-1:0] fire;
  logic [NCH-1:0] tmr_idle;

  assign raw_flags[CH_TEMP] = temp_low_raw;
  assign raw_flags[CH_EXT]  = ext_low_raw;
  assign raw_flags[CH_OVLD] = fb_high_raw;
  assign raw_flags[CH_OVV]  = vdd_high_raw;

  fq_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_flags),
    .q     (sync_lvl)
  );

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_ch
      fq_hold_timer #(.LIMIT(LIMITS[ch])) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .level (sync_lvl[ch]),
        .fire  (fire[ch]),
        .idle  (tmr_idle[ch])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_req   <= '0;
      fault_latch <= '0;
    end else begin
      fault_req   <= fire;
      fault_latch <= fire & LATCH_MASK;
    end
  end

endmodule

// File: rtl/fq_checker.sv
module fq_checker #(
  parameter logic [3:0] LATCH_MASK = 4'b1011
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] sync_lvl,
  input logic [3:0] tmr_idle,
  input logic [3:0] fault_req,
  input logic [3:0] fault_latch
);

  genvar ch;
  generate
    for (ch = 0; ch < 4; ch++) begin : g_a
      assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req[ch] |=> !fault_req[ch]);

      assert_req_needs_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req[ch] |-> $past(sync_lvl[ch]));

      assert_clear_on_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_lvl[ch] |=> tmr_idle[ch]);

      assert_tag_with_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req[ch] |-> (fault_latch[ch] == LATCH_MASK[ch]));

      assert_no_tag_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_req[ch] |-> !fault_latch[ch]);
    end
  endgenerate

  assert_ovv_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req[3] |-> ($past(sync_lvl[3]) && $past(!tmr_idle[3]) == 1'b0));

endmodule

bind fault_qualifier fq_checker #(.LATCH_MASK(LATCH_MASK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_lvl    (sync_lvl),
  .tmr_idle    (tmr_idle),
  .fault_req   (fault_req),
  .fault_latch (fault_latch)
);

// File: tb/fault_qualifier_tb.sv
module fault_qualifier_tb;

  localparam int unsigned T_TEMP = 6;
  localparam int unsigned T_EXT  = 2;
  localparam int unsigned T_OVLD = 9;
  localparam bit          OL_LAT = 1'b0;
  localparam int          TICK_DIV = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] raw = '0;
  logic [3:0] fault_req;
  logic [3:0] fault_latch;

  always #2 clk = ~clk;

  fault_qualifier #(
    .TEMP_TICKS(T_TEMP), .EXT_TICKS(T_EXT), .OVLD_TICKS(T_OVLD),
    .OVV_TICKS(0), .OVLD_LATCH(OL_LAT), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .temp_low_raw(raw[0]), .ext_low_raw(raw[1]),
    .fb_high_raw(raw[2]), .vdd_high_raw(raw[3]),
    .fault_req(fault_req), .fault_latch(fault_latch)
  );

  int checks = 0;
  int fails  = 0;
  int cyc_no = 0;
  int wd_cnt = 0;
  bit done_run = 0;

  // Behavioural reference state.
  int unsigned lim [4] = '{T_TEMP, T_EXT, T_OVLD, 0};
  bit          tagm[4] = '{1'b1, 1'b1, OL_LAT, 1'b1};
  int          held[4];
  bit          fired[4];
  bit          was_hi[4];
  bit          dly[4][$];
  int          seen[4];

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      held[c] = 0; fired[c] = 0; was_hi[c] = 0;
      dly[c].delete();
      dly[c].push_back(1'b0);
      dly[c].push_back(1'b0);
    end
  endtask

  // One clock: inputs already held; step the model over the edge and compare.
  task automatic step();
    bit er;
    bit s;
    string rq;
    @(posedge clk);
    #1;
    cyc_no++;
    for (int c = 0; c < 4; c++) begin
      s  = dly[c][0];
      er = 1'b0;
      if (lim[c] == 0) begin
        er = s && !was_hi[c];
        was_hi[c] = s;
      end else if (!s) begin
        held[c] = 0; fired[c] = 0;
      end else if (tick) begin
        if (held[c] < int'(lim[c])) held[c]++;
        if (held[c] == int'(lim[c]) && !fired[c]) begin er = 1'b1; fired[c] = 1'b1; end
      end
      void'(dly[c].pop_front());
      dly[c].push_back(raw[c]);
      case (c)
        0: rq = "R3";
        1: rq = "R4";
        2: rq = "R5";
        default: rq = "R6";
      endcase
      check(fault_req[c] == er, rq, fault_req[c], er);
      check(fault_latch[c] == (er & tagm[c]), "R7", fault_latch[c], er & tagm[c]);
      if (fault_req[c]) seen[c]++;
    end
  endtask

  task automatic drive(input logic [3:0] r, input int n, input bit ticks_on);
    for (int i = 0; i < n; i++) begin
      raw  = r;
      tick = ticks_on && ((cyc_no % TICK_DIV) == 0);
      step();
    end
  endtask

  task automatic clear_seen();
    for (int c = 0; c < 4; c++) seen[c] = 0;
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 20000 && !done_run) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd_cnt, 20000);
      report();
    end
  end

  initial begin
    model_reset();
    clear_seen();
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet during reset
    check(fault_req == 4'b0, "R1", fault_req, 0);
    check(fault_latch == 4'b0, "R1", fault_latch, 0);
    rst_n = 1'b1;
    drive(4'b0000, 1, 1'b1);
    check(fault_req == 4'b0, "R1", fault_req, 0);

    // R3/R8: long thermal hold gives exactly one pulse
    clear_seen();
    drive(4'b0001, 40, 1'b1);
    drive(4'b0000, 5, 1'b1);
    check(seen[0] == 1, "R8", seen[0], 1);

    // R9: broken holds never qualify
    clear_seen();
    drive(4'b0001, 10, 1'b1);
    drive(4'b0000, 2, 1'b1);
    drive(4'b0001, 10, 1'b1);
    drive(4'b0000, 5, 1'b1);
    check(seen[0] == 0, "R9", seen[0], 0);

    // R4: deep threshold fires too, independently of the shallow one
    clear_seen();
    drive(4'b0011, 30, 1'b1);
    drive(4'b0000, 5, 1'b1);
    check(seen[1] == 1, "R4", seen[1], 1);
    check(seen[0] == 1, "R3", seen[0], 1);

    // R5: overload hold
    clear_seen();
    drive(4'b0100, 40, 1'b1);
    drive(4'b0000, 5, 1'b1);
    check(seen[2] == 1, "R5", seen[2], 1);

    // R10: no ticks, no progress
    clear_seen();
    drive(4'b0111, 60, 1'b0);
    drive(4'b0000, 5, 1'b1);
    check(seen[0] + seen[1] + seen[2] == 0, "R10", seen[0] + seen[1] + seen[2], 0);

    // R2/R6: over-voltage latency and re-fire after a drop
    clear_seen();
    raw = 4'b1000; tick = 1'b0; step();
    check(fault_req[3] == 1'b0, "R2", fault_req[3], 0);
    step();
    check(fault_req[3] == 1'b0, "R2", fault_req[3], 0);
    step();
    check(fault_req[3] == 1'b1, "R6", fault_req[3], 1);
    drive(4'b1000, 5, 1'b1);
    drive(4'b0000, 3, 1'b1);
    drive(4'b1000, 5, 1'b1);
    drive(4'b0000, 4, 1'b1);
    check(seen[3] == 2, "R8", seen[3], 2);

    done_run = 1;
    report();
  end

endmodule